// File: doc/BRIEF.md
# Serial Multiply-Accumulate Neural Layer

This block computes one layer of a feed-forward neural network with three neurons that share a single serial input line. A start pulse opens a pattern. In that same cycle every neuron's accumulator is loaded with the neuron's own bias. The following input samples, each marked by `in_valid`, are taken one per accepted cycle. In each accepted cycle every neuron multiplies the sample by the weight for that input position, read from its private constant weight table, and adds the product to its accumulator.

When the last input position has been consumed, the three net values are copied into holding registers. A counter then walks an output multiplexer across them in neuron order. A single activation unit, shared by the whole layer, maps each selected net value to an unsigned 8-bit level. It uses a saturating second-order approximation of the sigmoid. Because the finished nets sit in holding registers, the next pattern can start accumulating while the previous one is still draining.

Top module: `nnl_layer`

## Requirements
- R1: While `rst` is high, and after its release until a pattern completes, `out_valid` stays 0.
- R2: A `start` pulse seen while no pattern is accumulating loads every accumulator with its bias. The default biases are 100, -50 and 0 for neurons 0, 1 and 2, as 20-bit signed values. With all-zero samples, each output therefore equals the activation of the bias.
- R3: Each neuron's net value is its bias plus the sum of x[i]*w[n][i], using 8-bit signed samples and weights with sign-extended products added into a 20-bit signed accumulator. The default weights for input positions 0, 1 and 2 are (16, -8, 4) for neuron 0, (-32, 12, 20) for neuron 1 and (5, 5, -7) for neuron 2.
- R4: A pattern takes exactly 3 samples, and only cycles with `in_valid` high count. Cycles without `in_valid` stall accumulation without changing the sum.
- R5: For each pattern, `out_valid` is high for exactly 3 consecutive cycles, carrying neurons 0, 1 and 2 in that order. It first rises at the clock edge right after the edge that accepts the last sample.
- R6: A net value at or above +2048 gives output 255. A net value at or below -2048 gives output 0.
- R7: For a net value z with |z| < 2048, let q = (|z|*(4096-|z|)) >> 15. The output is 128+q for z >= 0 and 127-q for z < 0.
- R8: A `start` pulse while a pattern is accumulating is ignored. It does not reload biases or restart the input position.
- R9: `in_valid` samples that arrive while no pattern is accumulating are ignored.
- R10: A new pattern may start in the cycle after the previous pattern's last sample, and both patterns' outputs are correct and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a pattern and loads the biases |
| in_valid | input | 1 | Marks a sample on `in_data` |
| in_data | input | 8 | Signed input sample |
| out_valid | output | 1 | Marks an activated neuron output |
| out_data | output | 8 | Unsigned activation level |

## Verification
The assertions check on every cycle that reset silences the output and that stalled or repeated-start cycles leave the input position untouched. They also check that an idle layer never begins accumulating without a start pulse, that output bursts never exceed the neuron count, and that a selected net beyond either limit always yields the matching saturation level. Only the bench's scenarios can show the arithmetic: correct net sums for positive and negative weights, the quadratic curve near zero, and the exact ±2048 boundaries. Likewise, only the bench can show that outputs arrive in neuron order, and that overlapping patterns keep their results separate.

// File: rtl/nnl_pkg.sv
package nnl_pkg;

  // Control phase of the accumulate side
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_ACC  = 1'b1
  } acc_phase_e;

  // Two's-complement magnitude, same width as the operand
  function automatic logic [31:0] mag32(input logic signed [31:0] v);
    return (v < 0) ? 32'(-v) : 32'(v);
  endfunction

endpackage

// File: rtl/nnl_ctrl.sv
module nnl_ctrl #(
  parameter int N_IN  = 3,
  parameter int N_NEU = 3,
  localparam int IDXW = (N_IN  > 1) ? $clog2(N_IN)  : 1,
  localparam int SELW = (N_NEU > 1) ? $clog2(N_NEU) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            in_valid,
  output logic            acc_load,
  output logic            mac_en,
  output logic            last_take,
  output logic [IDXW-1:0] in_idx,
  output logic            acc_busy,
  output logic            drain_busy,
  output logic [SELW-1:0] drain_sel
);
  import nnl_pkg::*;

  localparam logic [IDXW-1:0] IDX_LAST = IDXW'(N_IN - 1);
  localparam logic [SELW-1:0] SEL_LAST = SELW'(N_NEU - 1);

  acc_phase_e phase;

  assign acc_busy  = (phase == PH_ACC);
  assign acc_load  = (phase == PH_IDLE) && start;
  assign mac_en    = acc_busy && in_valid;
  assign last_take = mac_en && (in_idx == IDX_LAST);

  // Accumulate side: phase and input position
  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      in_idx <= '0;
    end else if (acc_load) begin
      phase  <= PH_ACC;
      in_idx <= '0;
    end else if (mac_en) begin
      if (last_take) begin
        phase  <= PH_IDLE;
        in_idx <= '0;
      end else begin
        in_idx <= in_idx + 1'b1;
      end
    end
  end

  // Drain side: steps the output multiplexer once per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      drain_busy <= 1'b0;
      drain_sel  <= '0;
    end else if (last_take) begin
      drain_busy <= 1'b1;
      drain_sel  <= '0;
    end else if (drain_busy) begin
      if (drain_sel == SEL_LAST) begin
        drain_busy <= 1'b0;
        drain_sel  <= '0;
      end else begin
        drain_sel <= drain_sel + 1'b1;
      end
    end
  end

endmodule

// File: rtl/nnl_neuron.sv
module nnl_neuron #(
  parameter int N_IN = 3,
  parameter int DW   = 8,
  parameter int AW   = 20,
  parameter logic [N_IN*DW-1:0] WROM = '0,
  parameter logic [AW-1:0]      BIAS = '0,
  localparam int IDXW = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int PW   = 2 * DW
) (
  input  logic                 clk,
  input  logic                 acc_load,
  input  logic                 mac_en,
  input  logic                 last_take,
  input  logic [IDXW-1:0]      in_idx,
  input  logic signed [DW-1:0] x,
  output logic signed [AW-1:0] held_net
);

  logic signed [DW-1:0] wtab [N_IN];
  logic signed [DW-1:0] w_sel;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_next;

  // Constant weight table, one entry per input position
  for (genvar i = 0; i < N_IN; i++) begin : g_wtab
    assign wtab[i] = WROM[i*DW +: DW];
  end

  assign w_sel    = wtab[in_idx];
  assign prod     = x * w_sel;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
  assign acc_next = acc + prod_ext;

  always_ff @(posedge clk) begin
    if (acc_load) begin
      acc <= BIAS;
    end else if (mac_en) begin
      acc <= acc_next;
    end
  end

  // Finished net value, kept while the next pattern accumulates
  always_ff @(posedge clk) begin
    if (last_take) begin
      held_net <= acc_next;
    end
  end

endmodule

// File: rtl/nnl_act.sv
module nnl_act #(
  parameter int AW     = 20,
  parameter int OW     = 8,
  parameter int LOG2_L = 11,
  localparam int SH    = 2 * LOG2_L - (OW - 1),
  localparam int PRW   = 2 * LOG2_L + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 net_valid,
  input  logic signed [AW-1:0] net,
  output logic                 y_valid,
  output logic [OW-1:0]        y
);

  localparam logic signed [AW-1:0] LIM_HI = AW'(1 << LOG2_L);
  localparam logic signed [AW-1:0] LIM_LO = -LIM_HI;
  localparam logic [PRW-1:0]       TWO_L  = PRW'(2) << LOG2_L;
  localparam logic [OW-1:0]        MID    = OW'(1) << (OW - 1);
  localparam logic [OW-1:0]        Y_MAX  = '1;

  logic                 neg;
  logic [AW-1:0]        mag_full;
  logic [PRW-1:0]       mag;
  logic [PRW-1:0]       span;
  logic [2*PRW-1:0]     prod;
  logic [OW-2:0]        q;
  logic [OW-1:0]        y_next;

  assign neg      = net[AW-1];
  assign mag_full = neg ? AW'(-net) : AW'(net);
  assign mag      = PRW'(mag_full[LOG2_L-1:0]);
  assign span     = TWO_L - mag;
  assign prod     = (2*PRW)'(mag) * (2*PRW)'(span);
  assign q        = prod[SH +: (OW-1)];

  always_comb begin
    if (net >= LIM_HI) begin
      y_next = Y_MAX;
    end else if (net <= LIM_LO) begin
      y_next = '0;
    end else if (!neg) begin
      y_next = MID + OW'(q);
    end else begin
      y_next = (MID - 1'b1) - OW'(q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_valid <= 1'b0;
    end else begin
      y_valid <= net_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (net_valid) begin
      y <= y_next;
    end
  end

endmodule

// File: rtl/nnl_layer.sv
module nnl_layer #(
  parameter int N_IN   = 3,
  parameter int N_NEU  = 3,
  parameter int DW     = 8,
  parameter int AW     = 20,
  parameter int OW     = 8,
  parameter int LOG2_L = 11,
  parameter logic [N_NEU*N_IN*DW-1:0] WEIGHTS =
    {8'hF9, 8'h05, 8'h05, 8'h14, 8'h0C, 8'hE0, 8'h04, 8'hF8, 8'h10},
  parameter logic [N_NEU*AW-1:0] BIASES =
    {20'h00000, 20'hFFFCE, 20'h00064}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [OW-1:0] out_data
);

  localparam int IDXW = (N_IN  > 1) ? $clog2(N_IN)  : 1;
  localparam int SELW = (N_NEU > 1) ? $clog2(N_NEU) : 1;

  logic                 acc_load;
  logic                 mac_en;
  logic                 last_take;
  logic [IDXW-1:0]      in_idx;
  logic                 acc_busy;
  logic                 drain_busy;
  logic [SELW-1:0]      drain_sel;
  logic signed [AW-1:0] held [N_NEU];
  logic signed [AW-1:0] sel_net;

  nnl_ctrl #(
    .N_IN  (N_IN),
    .N_NEU (N_NEU)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .in_valid   (in_valid),
    .acc_load   (acc_load),
    .mac_en     (mac_en),
    .last_take  (last_take),
    .in_idx     (in_idx),
    .acc_busy   (acc_busy),
    .drain_busy (drain_busy),
    .drain_sel  (drain_sel)
  );

  for (genvar n = 0; n < N_NEU; n++) begin : g_neu
    nnl_neuron #(
      .N_IN (N_IN),
      .DW   (DW),
      .AW   (AW),
      .WROM (WEIGHTS[n*N_IN*DW +: N_IN*DW]),
      .BIAS (BIASES[n*AW +: AW])
    ) u_neuron (
      .clk       (clk),
      .acc_load  (acc_load),
      .mac_en    (mac_en),
      .last_take (last_take),
      .in_idx    (in_idx),
      .x         (in_data),
      .held_net  (held[n])
    );
  end

  // Output multiplexer driven by the drain counter
  assign sel_net = held[drain_sel];

  nnl_act #(
    .AW     (AW),
    .OW     (OW),
    .LOG2_L (LOG2_L)
  ) u_act (
    .clk       (clk),
    .rst       (rst),
    .net_valid (drain_busy),
    .net       (sel_net),
    .y_valid   (out_valid),
    .y         (out_data)
  );

endmodule

// File: rtl/nnl_layer_chk.sv
module nnl_layer_chk #(
  parameter int N_IN   = 3,
  parameter int N_NEU  = 3,
  parameter int AW     = 20,
  parameter int OW     = 8,
  parameter int LOG2_L = 11,
  localparam int IDXW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [OW-1:0]        out_data,
  input logic                 acc_busy,
  input logic [IDXW-1:0]      in_idx,
  input logic                 drain_busy,
  input logic signed [AW-1:0] sel_net
);

  localparam logic signed [AW-1:0] LIM = AW'(1 << LOG2_L);
  localparam logic [OW-1:0]        TOP = '1;

  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !out_valid) begin
      run_len <= 0;
    end else begin
      run_len <= run_len + 1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    acc_busy && !in_valid |=> acc_busy && $stable(in_idx));

  // R8
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    acc_busy && start && !in_valid |=> $stable(in_idx));

  // R9
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_busy && !start |=> !acc_busy);

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> run_len < N_NEU);

  // R5
  drain_out_chk: assert property (@(posedge clk) disable iff (rst)
    drain_busy |=> out_valid);

  // R6
  sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
    drain_busy && (sel_net >= LIM) |=> out_data == TOP);

  // R6
  sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
    drain_busy && (sel_net <= -LIM) |=> out_data == '0);

endmodule

bind nnl_layer nnl_layer_chk #(
  .N_IN   (N_IN),
  .N_NEU  (N_NEU),
  .AW     (AW),
  .OW     (OW),
  .LOG2_L (LOG2_L)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .acc_busy   (acc_busy),
  .in_idx     (in_idx),
  .drain_busy (drain_busy),
  .sel_net    (sel_net)
);

// File: tb/nnl_layer_tb.sv
module nnl_layer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  nnl_layer u_dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  // R3 default weights and R2 default biases
  int W [3][3] = '{'{16, -8, 4}, '{-32, 12, 20}, '{5, 5, -7}};
  int B [3]    = '{100, -50, 0};

  localparam int MODE_GAP  = 1;
  localparam int MODE_MID  = 2;
  localparam int MODE_TIME = 4;
  localparam int MODE_IDLE = 8;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R6 / R7 activation model
  function automatic int act_model(input int z);
    int a;
    int q;
    if (z >= 2048) return 255;
    if (z <= -2048) return 0;
    a = (z < 0) ? -z : z;
    q = (a * (4096 - a)) >>> 15;
    return (z >= 0) ? 128 + q : 127 - q;
  endfunction

  task automatic run_pat(input int x0, input int x1, input int x2,
                         input string tag, input int mode);
    int xs [3];
    xs = '{x0, x1, x2};
    for (int n = 0; n < 3; n++) begin
      int net;
      net = B[n];
      for (int i = 0; i < 3; i++) net += xs[i] * W[n][i];
      exp_q.push_back(act_model(net));
      tag_q.push_back($sformatf("%s n%0d", tag, n));
    end
    @(negedge clk);
    if ((mode & MODE_IDLE) != 0) begin
      // R9: samples with no pattern open
      in_valid = 1'b1;
      in_data  = 8'd99;
      @(negedge clk);
      in_data  = 8'd77;
      @(negedge clk);
      in_valid = 1'b0;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (i == 1 && (mode & MODE_GAP) != 0) begin
        // R4: stall cycles with junk on the bus
        in_valid = 1'b0;
        in_data  = 8'h55;
        @(negedge clk);
        @(negedge clk);
      end
      if (i == 1 && (mode & MODE_MID) != 0) begin
        // R8: start during accumulation
        in_valid = 1'b0;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
      end
      in_valid = 1'b1;
      in_data  = 8'(xs[i]);
      @(negedge clk);
    end
    in_valid = 1'b0;
    if ((mode & MODE_TIME) != 0) begin
      chk("R5 no output one cycle after last sample", int'(out_valid), 0);
      @(negedge clk);
      chk("R5 output valid after next edge", int'(out_valid), 1);
    end
  endtask

  // Monitor: pops expected results in order
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk("R5 unexpected output", int'(out_data), -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'(out_data), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid idle after reset", int'(out_valid), 0);

    run_pat(0, 0, 0, "R2 zero samples", MODE_TIME);
    repeat (4) @(negedge clk);
    run_pat(10, 20, 30, "R3 small positive", 0);
    repeat (4) @(negedge clk);
    run_pat(127, 127, 127, "R3 full scale", 0);
    repeat (4) @(negedge clk);
    run_pat(-128, 127, -128, "R6 both saturations", 0);
    repeat (4) @(negedge clk);
    run_pat(127, 10, -1, "R6 net exactly +2048", 0);
    repeat (4) @(negedge clk);
    run_pat(-128, 12, -1, "R6 net exactly -2048", 0);
    repeat (4) @(negedge clk);
    run_pat(127, 10, -3, "R7 net just below +2048", 0);
    repeat (4) @(negedge clk);
    run_pat(-3, 4, 1, "R7 small negative", 0);
    repeat (4) @(negedge clk);
    run_pat(7, -9, 33, "R4 stalled samples", MODE_GAP | MODE_TIME);
    repeat (4) @(negedge clk);
    run_pat(40, -40, 25, "R8 start while busy", MODE_MID);
    repeat (4) @(negedge clk);
    run_pat(-20, 60, -5, "R9 idle samples", MODE_IDLE);
    repeat (4) @(negedge clk);
    run_pat(50, 50, 50, "R10 first", 0);
    run_pat(-60, 3, 90, "R10 second", 0);
    run_pat(1, -1, 2, "R10 third", 0);
    repeat (10) @(negedge clk);
    chk("R5 all expected outputs seen", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule